// File: doc/BRIEF.md
# Interval / Free-Running Compare Timer

A 16-bit up-counter that advances once for each count-enable tick while its run bit is set. A mode bit selects between two behaviours. In interval mode the counter goes back to zero one tick after it has matched the primary compare register, so the period is the compare value plus one. In free-running mode the counter covers the whole 16-bit range, wraps to zero and latches an overflow flag that software clears.

Four match channels watch the counter at all times. Channel 0 is the primary compare register and channel 1 is a second plain compare register. Channels 2 and 3 are dual-purpose registers. They raise a match pulse only while their control bit selects compare mode. Every match pulse lasts one cycle and is tied to a count tick. All registers are loaded through a write-only port of address, data and strobe.

Top module: `tick_cmp_timer`

## Requirements
- R1: On each system clock where `tick` is high and the run bit (control register, address 0, bit 0) is 1, the counter changes by exactly one step: it adds one, or it clears as R3 describes.
- R2: Control bit 1 selects the mode: 1 is interval operation and 0 is free-running operation.
- R3: In interval mode, a running tick taken while the count equals channel 0's compare value (address 2) clears the count to 0. Match bit 0 pulses in the cycle after that tick, and the period is therefore (compare + 1) ticks.
- R4: In free-running mode the count goes from FFFFh to 0000h on a running tick and sets the overflow flag. Passing channel 0's compare value does not clear the count, so one period is 65536 ticks.
- R5: Channel i (compare register at address 2+i) pulses `match_irq[i]` in the cycle after a running tick taken while the count equals its value. Channels 1 to 3 never change the count.
- R6: Channels 2 and 3 raise match pulses only when control bits 2 and 3 respectively are 1 (compare mode). At 0 (capture mode) they stay silent, and each keeps its stored compare value for when compare mode returns.
- R7: A match pulse lasts one cycle per qualifying tick. No pulse appears in a cycle that does not follow a running tick, even while the count rests on a compare value.
- R8: The overflow flag holds until a write to address 1 with bit 1 set clears it. If that write and an overflow fall in the same cycle, the flag stays set.
- R9: With the run bit at 0, ticks leave the count unchanged. A write to address 1 with bit 0 set clears the count to 0, and this clear wins over a tick in the same cycle.
- R10: After reset the count is 0, no match bit is set, the overflow flag is 0, all control bits are 0 and all compare registers hold 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count-enable tick, one system clock wide per count |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 control, 1 command, 2 to 5 compare channels 0 to 3 |
| wr_data | input | 16 | Register write data |
| count | output | 16 | Current counter value |
| match_irq | output | 4 | One-cycle match pulse, one bit per channel |
| ovf_flag | output | 1 | Sticky free-running overflow flag |

## Verification
Some properties are checked on every cycle. The counter either takes a single step or holds, the interval clear follows the primary match, and a match pulse only appears after a running tick. A capture-mode channel never pulses, and the overflow flag rises and falls only under its set-wins rule. Some behaviour only the directed scenarios can show. These are the full periods of compare+1 and 65536 ticks, and that channels 1 to 3 leave the count alone. They also show that a dual-purpose channel keeps its value through capture mode, and the exact cycles at which the pulses land.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   // register addresses
   localparam int unsigned ADDR_CTRL = 0;
   localparam int unsigned ADDR_CMD  = 1;
   localparam int unsigned ADDR_CMP0 = 2;
   // control register bits
   localparam int unsigned CTRL_RUN  = 0;
   localparam int unsigned CTRL_IVL  = 1;
   localparam int unsigned CTRL_CCM0 = 2;
   // command strobe bits
   localparam int unsigned CMD_CLR   = 0;
   localparam int unsigned CMD_OVC   = 1;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned NUM_CC = 2,
   parameter int unsigned ADDR_W = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             wr_addr,
   input  logic [CNT_W-1:0]              wr_data,
   output logic                          run,
   output logic                          ivl,
   output logic [NUM_CC-1:0]             cc_cmp,
   output logic                          cnt_clr,
   output logic                          ovf_clr,
   output logic [NUM_CH-1:0][CNT_W-1:0]  cmp_val
);
   localparam int unsigned CTRL_W = CTRL_CCM0 + NUM_CC;

   logic [CTRL_W-1:0]            ctrl_q;
   logic [NUM_CH-1:0][CNT_W-1:0] cmp_q;
   logic                         cmd_sel;

   assign cmd_sel = wr_en && (wr_addr == ADDR_W'(ADDR_CMD));
   assign cnt_clr = cmd_sel && wr_data[CMD_CLR];
   assign ovf_clr = cmd_sel && wr_data[CMD_OVC];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_en && (wr_addr == ADDR_W'(ADDR_CTRL))) begin
         ctrl_q <= wr_data[CTRL_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q <= '0;
      end else begin
         for (int i = 0; i < NUM_CH; i++) begin
            if (wr_en && (wr_addr == ADDR_W'(ADDR_CMP0 + i))) begin
               cmp_q[i] <= wr_data;
            end
         end
      end
   end

   assign run     = ctrl_q[CTRL_RUN];
   assign ivl     = ctrl_q[CTRL_IVL];
   assign cc_cmp  = ctrl_q[CTRL_W-1:CTRL_CCM0];
   assign cmp_val = cmp_q;
endmodule

// File: rtl/tmr_match.sv
module tmr_match #(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned NUM_CC = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          tick_run,
   input  logic [CNT_W-1:0]              count,
   input  logic [NUM_CH-1:0][CNT_W-1:0]  cmp_val,
   input  logic [NUM_CC-1:0]             cc_cmp,
   output logic [NUM_CH-1:0]             hit,
   output logic [NUM_CH-1:0]             irq
);
   localparam int unsigned FIRST_CC = NUM_CH - NUM_CC;

   logic [NUM_CH-1:0] active;
   logic [NUM_CH-1:0] irq_q;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      assign hit[i] = (count == cmp_val[i]);
      if (i >= FIRST_CC) begin : g_dual
         assign active[i] = cc_cmp[i - FIRST_CC];
      end else begin : g_plain
         assign active[i] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= '0;
      end else begin
         irq_q <= {NUM_CH{tick_run}} & hit & active;
      end
   end

   assign irq = irq_q;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_run,
   input  logic             ivl,
   input  logic             clr,
   input  logic             hit0,
   input  logic             ovf_clr,
   output logic [CNT_W-1:0] count,
   output logic             ovf
);
   logic [CNT_W-1:0] cnt_q;
   logic             ovf_q;
   logic             ovf_set;

   assign ovf_set = tick_run && !clr && !ivl && (&cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (tick_run) begin
         cnt_q <= (ivl && hit0) ? '0 : cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q <= 1'b0;
      end else if (ovf_set) begin
         ovf_q <= 1'b1;
      end else if (ovf_clr) begin
         ovf_q <= 1'b0;
      end
   end

   assign count = cnt_q;
   assign ovf   = ovf_q;
endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned NUM_CC = 2,
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   output logic [CNT_W-1:0]  count,
   output logic [NUM_CH-1:0] match_irq,
   output logic              ovf_flag
);
   if (NUM_CC >= NUM_CH) begin : g_bad_cc
      $error("NUM_CC must leave channel 0 as a plain compare channel");
   end
   if (ADDR_CMP0 + NUM_CH > (2 ** ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the compare registers");
   end
   if (CTRL_CCM0 + NUM_CC > CNT_W) begin : g_bad_ctrl
      $error("control register does not fit in the data width");
   end

   logic                         run;
   logic                         ivl;
   logic [NUM_CC-1:0]            cc_cmp;
   logic                         cnt_clr;
   logic                         ovf_clr;
   logic [NUM_CH-1:0][CNT_W-1:0] cmp_val;
   logic [NUM_CH-1:0]            hit;
   logic                         tick_run;

   assign tick_run = tick && run;

   tmr_regs #(
      .CNT_W(CNT_W), .NUM_CH(NUM_CH), .NUM_CC(NUM_CC), .ADDR_W(ADDR_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .run(run), .ivl(ivl), .cc_cmp(cc_cmp),
      .cnt_clr(cnt_clr), .ovf_clr(ovf_clr), .cmp_val(cmp_val)
   );

   tmr_match #(
      .CNT_W(CNT_W), .NUM_CH(NUM_CH), .NUM_CC(NUM_CC)
   ) u_match (
      .clk(clk), .rst_n(rst_n), .tick_run(tick_run), .count(count),
      .cmp_val(cmp_val), .cc_cmp(cc_cmp), .hit(hit), .irq(match_irq)
   );

   tmr_counter #(
      .CNT_W(CNT_W)
   ) u_counter (
      .clk(clk), .rst_n(rst_n), .tick_run(tick_run), .ivl(ivl),
      .clr(cnt_clr), .hit0(hit[0]), .ovf_clr(ovf_clr),
      .count(count), .ovf(ovf_flag)
   );
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned NUM_CC = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              run,
   input logic              ivl,
   input logic [NUM_CC-1:0] cc_cmp,
   input logic              cnt_clr,
   input logic              ovf_clr,
   input logic [CNT_W-1:0]  cmp0,
   input logic [CNT_W-1:0]  count,
   input logic [NUM_CH-1:0] irq,
   input logic              ovf
);
   localparam int unsigned FIRST_CC = NUM_CH - NUM_CC;

   logic step;
   logic wrap_set;
   assign step     = tick && run && !cnt_clr;
   assign wrap_set = step && !ivl && (&count);

   // R1: a running tick moves the count one step unless the interval clear applies
   assert_single_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !(ivl && count == cmp0)) |=> (count == $past(count) + 1'b1));

   // R3: interval clear on the tick after the primary match
   assert_interval_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && ivl && count == cmp0) |=> (count == '0));

   // R9: no running tick and no clear command means the count holds
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!(tick && run) && !cnt_clr) |=> $stable(count));

   // R9: the clear command forces zero
   assert_cmd_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_clr |=> (count == '0));

   // R7: every match pulse follows a running tick
   assert_pulse_qualified_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq != '0) |-> $past(tick && run));

   // R6: a dual-purpose channel in capture mode stays silent
   for (genvar k = 0; k < NUM_CC; k++) begin : g_cc
      assert_capture_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
         irq[FIRST_CC + k] |-> $past(cc_cmp[k]));
   end

   // R4: the overflow flag rises only on a free-running wrap
   assert_ovf_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf) |-> $past(wrap_set));

   // R8: set wins over clear
   assert_ovf_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_set |=> ovf);

   // R8: clear without set drops the flag
   assert_ovf_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_clr && !wrap_set) |=> !ovf);
endmodule

bind tick_cmp_timer tmr_chk #(
   .CNT_W(CNT_W), .NUM_CH(NUM_CH), .NUM_CC(NUM_CC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .ivl(ivl),
   .cc_cmp(cc_cmp), .cnt_clr(cnt_clr), .ovf_clr(ovf_clr),
   .cmp0(cmp_val[0]), .count(count), .irq(match_irq), .ovf(ovf_flag)
);

// File: tb/tick_cmp_timer_bench.sv
`timescale 1ns/1ps
module tick_cmp_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] count;
   logic [3:0]  match_irq;
   logic        ovf_flag;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   tick_cmp_timer u_tick_cmp_timer (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .count(count),
      .match_irq(match_irq), .ovf_flag(ovf_flag)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // all driving happens right after a falling edge
   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic ticks(input int n);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R10", "count", 32'(count), 0);
      chk("R10", "irq", 32'(match_irq), 0);
      chk("R10", "ovf", 32'(ovf_flag), 0);
      ticks(3);
      chk("R10", "count with run bit 0 after reset", 32'(count), 0);
   endtask

   task automatic t_interval;
      wr(3'd2, 16'd4);
      wr(3'd0, 16'h0003);
      ticks(4);
      chk("R1", "count after 4 ticks", 32'(count), 4);
      chk("R3", "no pulse before match", 32'(match_irq), 0);
      ticks(1);
      chk("R3", "clear after match", 32'(count), 0);
      chk("R3", "primary pulse", 32'(match_irq), 32'h1);
      idle(1);
      chk("R7", "pulse one cycle", 32'(match_irq), 0);
      ticks(1);
      chk("R3", "one tick after clear", 32'(count), 1);
      ticks(3);
      chk("R3", "count before second wrap", 32'(count), 4);
      ticks(1);
      chk("R3", "period compare+1", 32'(count), 0);
      chk("R2", "no overflow in interval mode", 32'(ovf_flag), 0);
   endtask

   task automatic t_other_channels;
      wr(3'd1, 16'h0001);
      wr(3'd2, 16'd6);
      wr(3'd3, 16'd2);
      chk("R9", "clear command", 32'(count), 0);
      ticks(2);
      chk("R5", "count at ch1 value", 32'(count), 2);
      ticks(1);
      chk("R5", "ch1 pulse", 32'(match_irq), 32'h2);
      chk("R5", "ch1 leaves count going", 32'(count), 3);
      idle(5);
      chk("R7", "no repeat without ticks", 32'(match_irq), 0);
      chk("R7", "count held between ticks", 32'(count), 3);
   endtask

   task automatic t_run_gate;
      wr(3'd0, 16'h0002);
      ticks(3);
      chk("R9", "run bit 0 holds count", 32'(count), 3);
      chk("R9", "no pulse when stopped", 32'(match_irq), 0);
      wr(3'd0, 16'h0003);
      tick = 1'b1;
      wr(3'd1, 16'h0001);
      tick = 1'b0;
      chk("R9", "clear wins over tick", 32'(count), 0);
   endtask

   task automatic t_capture;
      wr(3'd4, 16'd3);
      wr(3'd5, 16'd5);
      ticks(3);
      ticks(1);
      chk("R6", "count 4", 32'(count), 4);
      chk("R6", "ch2 capture mode silent", 32'(match_irq), 0);
      ticks(1);
      ticks(1);
      chk("R6", "ch3 capture mode silent", 32'(match_irq), 0);
      wr(3'd0, 16'h000F);
      wr(3'd1, 16'h0001);
      ticks(3);
      ticks(1);
      chk("R6", "ch2 compare mode, value kept", 32'(match_irq), 32'h4);
      ticks(2);
      chk("R6", "ch3 compare mode", 32'(match_irq), 32'h8);
      ticks(1);
      chk("R3", "primary still clears", 32'(count), 0);
      chk("R5", "primary pulse at 6", 32'(match_irq), 32'h1);
   endtask

   task automatic t_free;
      wr(3'd0, 16'h0001);
      wr(3'd1, 16'h0001);
      ticks(7);
      chk("R4", "passes primary value", 32'(count), 7);
      ticks(65535 - 7);
      chk("R4", "reaches full scale", 32'(count), 32'hFFFF);
      chk("R4", "no flag before wrap", 32'(ovf_flag), 0);
      ticks(1);
      chk("R4", "wrap to zero", 32'(count), 0);
      chk("R4", "flag on wrap", 32'(ovf_flag), 1);
      ticks(3);
      chk("R8", "flag sticky", 32'(ovf_flag), 1);
      wr(3'd1, 16'h0002);
      chk("R8", "write-one clears flag", 32'(ovf_flag), 0);
      chk("R8", "clear leaves count", 32'(count), 3);
   endtask

   task automatic t_set_wins;
      ticks(65532);
      chk("R4", "full scale again", 32'(count), 32'hFFFF);
      tick = 1'b1;
      wr(3'd1, 16'h0002);
      tick = 1'b0;
      chk("R8", "set wins over clear", 32'(ovf_flag), 1);
      chk("R4", "wrap with clear write", 32'(count), 0);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_interval();
      t_other_channels();
      t_run_gate();
      t_capture();
      t_free();
      t_set_wins();
      finish_run();
   end

   initial begin
      repeat (195000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=1 expected=0");
      finish_run();
   end
endmodule